// File: doc/BRIEF.md
# Connection-Event Timing Tracker

This unit runs on the peripheral side of a low-energy radio link and keeps the receiver aligned with the central's schedule of connection events, even when packets are lost. Software loads the connection interval, the hop increment, a 37-bit mask of usable data channels and the summed sleep-clock accuracy of both ends. The unit then pulses `conn_start` to begin. From that point the unit counts microseconds from the last anchor point. For each event it presents the data channel and marks the listening period with an opening strobe and a closing strobe.

A strobe from the demodulator reports each detected access address. If one arrives while the window is open, the anchor moves to that instant and the schedule restarts one interval later. This happens before any CRC result is known. If the window closes with no detection, the unit keeps hopping: the expected arrival moves one interval further out and the channel advances. The listening window is widened on both sides in proportion to the time since the last anchor. The widening is limited to just under half an interval. Supervision timing is handled elsewhere and is not touched here.

Top module: `ce_tracker`

## Requirements
- R1: After reset, before any `conn_start`, the unit holds `chan_idx`=0, `event_cnt`=0, `sync_lost`=0 and no strobes, and `aa_detect` has no effect.
- R2: With T the expected arrival in µs after the last anchor and W the widening, `win_open` pulses when the anchor timer reaches T−W and `win_close` pulses when it reaches T+W, so the window is symmetric about T. The timer is zeroed by the anchor or by `conn_start`.
- R3: W = ceil(T × `sca_sum_ppm` / 1 000 000) + 16 µs, shown on `win_widen_us` and recomputed whenever T changes.
- R4: When a window closes without a detection, T grows by one connection interval while the anchor is kept, the channel advances and `event_cnt` increments.
- R5: An `aa_detect` sampled while the window is open makes that cycle the new anchor: the timer restarts from 0, T becomes one interval, and `anchor_upd` and `win_close` pulse together.
- R6: An `aa_detect` outside an open window is ignored: there is no `anchor_upd` and the window timing is unchanged.
- R7: The unmapped channel is u = (previous u + `hop_incr`) mod 37, with previous u = 0 at `conn_start`. If bit u of `chan_map` is set, `chan_idx` = u. Otherwise `chan_idx` is entry (u mod number of set bits) of the set bits listed from bit 0 upward.
- R8: `event_cnt` is a 16-bit count of ended events. Each event counts once, whether it ends by detection or by miss. It wraps.
- R9: If W would reach half the interval, W is held at half the interval − 1 and `sync_lost` is set. `sync_lost` stays set until `conn_start` or reset.
- R10: `conn_start` at any time restarts the connection. The timer and `event_cnt` go to 0, `sync_lost` clears, T becomes one interval and the channel is the first in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| conn_start | input | 1 | begin or restart tracking; the current instant becomes the anchor |
| conn_interval_us | input | IVL_W | connection interval in µs |
| hop_incr | input | 5 | hop increment |
| chan_map | input | 37 | usable data channels, bit n = channel n |
| sca_sum_ppm | input | SCA_W | central plus peripheral clock accuracy, ppm |
| aa_detect | input | 1 | access-address detected strobe from the demodulator |
| chan_idx | output | 6 | data channel of the current event |
| win_open | output | 1 | receive window opens (one cycle) |
| win_close | output | 1 | receive window ends (one cycle) |
| anchor_upd | output | 1 | anchor point moved (one cycle) |
| event_cnt | output | EVT_W | count of ended connection events |
| sync_lost | output | 1 | sticky: widening was clamped |
| win_widen_us | output | IVL_W | current one-sided widening in µs |

## Verification
The tracker is driven with three channel masks. An all-channels mask shows the plain modulo-37 sequence. A sparse five-channel mask forces remapping with wrap-around. A third case with a short interval and high clock error runs over a hundred missed events in a row. Each event is run either with a detection at the expected arrival or with no detection. This separates the anchor-restart path from the keep-hopping path: with a detection the next window moves back to one interval, and with no detection it moves out while widening grows. Accuracy values that give a non-integer ppm product exercise the upward rounding. The long miss run crosses the clamp point, after which a detection shows that `sync_lost` stays set while the window shrinks back. A stray detection outside the window and a restart in the middle of a connection cover the ignore and restart paths.

// File: rtl/ce_pkg.sv
package ce_pkg;
    localparam int NUM_CH         = 37;
    localparam int CH_W           = 6;
    localparam int HOP_W          = 5;
    localparam int WIDEN_FLOOR_US = 16;
    localparam int PPM_SCALE      = 1_000_000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OPEN = 2'd2
    } trk_st_e;
endpackage

// File: rtl/ce_chan_sel.sv
module ce_chan_sel
    import ce_pkg::*;
(
    input  logic [CH_W-1:0]   prev_unm,
    input  logic [HOP_W-1:0]  hop,
    input  logic [NUM_CH-1:0] used_map,
    output logic [CH_W-1:0]   unm,
    output logic [CH_W-1:0]   chan
);
    logic [CH_W:0]   sum;
    logic [CH_W-1:0] n_used;
    logic [CH_W-1:0] slot;
    logic [CH_W-1:0] seen;
    logic            found;

    always_comb begin
        sum = {1'b0, prev_unm} + (CH_W+1)'(hop);
        if (sum >= (CH_W+1)'(NUM_CH))
            unm = CH_W'(sum - (CH_W+1)'(NUM_CH));
        else
            unm = CH_W'(sum);

        n_used = '0;
        for (int i = 0; i < NUM_CH; i++)
            n_used = n_used + CH_W'(used_map[i]);

        slot = (n_used == '0) ? '0 : (unm % n_used);

        chan  = '0;
        seen  = '0;
        found = 1'b0;
        if (used_map[unm]) begin
            chan = unm;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (used_map[i]) begin
                    if (!found && seen == slot) begin
                        chan  = CH_W'(i);
                        found = 1'b1;
                    end
                    seen = seen + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ce_widen.sv
module ce_widen
    import ce_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int IVL_W  = 22,
    parameter int SCA_W  = 11
) (
    input  logic [TIME_W-1:0] target,
    input  logic [IVL_W-1:0]  interval,
    input  logic [SCA_W-1:0]  sca,
    output logic [IVL_W-1:0]  widen,
    output logic              clamp
);
    localparam int PW = TIME_W + SCA_W + 1;

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;
    logic [PW-1:0] raw;
    logic [PW-1:0] half;

    always_comb begin
        prod  = PW'(target) * PW'(sca);
        quot  = (prod + PW'(PPM_SCALE - 1)) / PW'(PPM_SCALE);
        raw   = quot + PW'(WIDEN_FLOOR_US);
        half  = PW'(interval >> 1);
        clamp = (raw >= half);
        widen = clamp ? IVL_W'(half - PW'(1)) : IVL_W'(raw);
    end
endmodule

// File: rtl/ce_tracker.sv
module ce_tracker
    import ce_pkg::*;
#(
    parameter int CLKS_PER_US = 16,
    parameter int IVL_W       = 22,
    parameter int TIME_W      = 32,
    parameter int SCA_W       = 11,
    parameter int EVT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conn_start,
    input  logic [IVL_W-1:0]  conn_interval_us,
    input  logic [HOP_W-1:0]  hop_incr,
    input  logic [NUM_CH-1:0] chan_map,
    input  logic [SCA_W-1:0]  sca_sum_ppm,
    input  logic              aa_detect,
    output logic [CH_W-1:0]   chan_idx,
    output logic              win_open,
    output logic              win_close,
    output logic              anchor_upd,
    output logic [EVT_W-1:0]  event_cnt,
    output logic              sync_lost,
    output logic [IVL_W-1:0]  win_widen_us
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    typedef struct packed {
        trk_st_e           st;
        logic [TIME_W-1:0] since;
        logic [TIME_W-1:0] target;
        logic [CH_W-1:0]   unm;
        logic [CH_W-1:0]   chan;
        logic [EVT_W-1:0]  evt;
        logic              lost;
        logic              open_p;
        logic              close_p;
        logic              anch_p;
        logic [PRE_W-1:0]  pre;
    } trk_s;

    trk_s trk_d, trk_q;

    logic              tick;
    logic              trk_active;
    logic [IVL_W-1:0]  widen;
    logic              clamp;
    logic [TIME_W-1:0] open_at;
    logic [TIME_W-1:0] close_at;
    logic [CH_W-1:0]   first_unm, first_chan;
    logic [CH_W-1:0]   next_unm, next_chan;

    ce_widen #(
        .TIME_W (TIME_W),
        .IVL_W  (IVL_W),
        .SCA_W  (SCA_W)
    ) u_widen (
        .target   (trk_q.target),
        .interval (conn_interval_us),
        .sca      (sca_sum_ppm),
        .widen    (widen),
        .clamp    (clamp)
    );

    ce_chan_sel u_sel_first (
        .prev_unm (CH_W'(0)),
        .hop      (hop_incr),
        .used_map (chan_map),
        .unm      (first_unm),
        .chan     (first_chan)
    );

    ce_chan_sel u_sel_next (
        .prev_unm (trk_q.unm),
        .hop      (hop_incr),
        .used_map (chan_map),
        .unm      (next_unm),
        .chan     (next_chan)
    );

    assign tick       = (trk_q.pre == PRE_W'(CLKS_PER_US - 1));
    assign trk_active = (trk_q.st != ST_IDLE);
    assign open_at    = trk_q.target - TIME_W'(widen);
    assign close_at   = trk_q.target + TIME_W'(widen);

    always_comb begin
        trk_d         = trk_q;
        trk_d.open_p  = 1'b0;
        trk_d.close_p = 1'b0;
        trk_d.anch_p  = 1'b0;
        trk_d.pre     = tick ? '0 : trk_q.pre + 1'b1;

        if (conn_start) begin
            trk_d.st     = ST_WAIT;
            trk_d.since  = '0;
            trk_d.target = TIME_W'(conn_interval_us);
            trk_d.unm    = first_unm;
            trk_d.chan   = first_chan;
            trk_d.evt    = '0;
            trk_d.lost   = 1'b0;
            trk_d.pre    = '0;
        end else if (trk_active) begin
            if (clamp)
                trk_d.lost = 1'b1;
            if (tick)
                trk_d.since = trk_q.since + 1'b1;

            unique case (trk_q.st)
                ST_WAIT: begin
                    if (tick && trk_q.since == open_at) begin
                        trk_d.st     = ST_OPEN;
                        trk_d.open_p = 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (aa_detect) begin
                        trk_d.st      = ST_WAIT;
                        trk_d.since   = '0;
                        trk_d.target  = TIME_W'(conn_interval_us);
                        trk_d.unm     = next_unm;
                        trk_d.chan    = next_chan;
                        trk_d.evt     = trk_q.evt + 1'b1;
                        trk_d.close_p = 1'b1;
                        trk_d.anch_p  = 1'b1;
                    end else if (tick && trk_q.since == close_at) begin
                        trk_d.st      = ST_WAIT;
                        trk_d.target  = trk_q.target + TIME_W'(conn_interval_us);
                        trk_d.unm     = next_unm;
                        trk_d.chan    = next_chan;
                        trk_d.evt     = trk_q.evt + 1'b1;
                        trk_d.close_p = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trk_q <= '0;
        else
            trk_q <= trk_d;
    end

    assign chan_idx     = trk_q.chan;
    assign win_open     = trk_q.open_p;
    assign win_close    = trk_q.close_p;
    assign anchor_upd   = trk_q.anch_p;
    assign event_cnt    = trk_q.evt;
    assign sync_lost    = trk_q.lost;
    assign win_widen_us = widen;
endmodule

// File: rtl/ce_tracker_chk.sv
module ce_tracker_chk
    import ce_pkg::*;
#(
    parameter int IVL_W = 22,
    parameter int EVT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conn_start,
    input logic              trk_active,
    input logic [IVL_W-1:0]  conn_interval_us,
    input logic [NUM_CH-1:0] chan_map,
    input logic [CH_W-1:0]   chan_idx,
    input logic              win_open,
    input logic              win_close,
    input logic              anchor_upd,
    input logic [EVT_W-1:0]  event_cnt,
    input logic              sync_lost,
    input logic [IVL_W-1:0]  win_widen_us
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_open && win_close)); // R2

    AST_ANCHOR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        anchor_upd |-> win_close); // R5

    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |-> (event_cnt == EVT_W'($past(event_cnt) + 1'b1))); // R8

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost && !conn_start) |=> sync_lost); // R9

    AST_WIDEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        trk_active |-> (win_widen_us < (conn_interval_us >> 1))); // R9

    AST_CHAN_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_active && chan_map != '0) |-> chan_map[chan_idx]); // R7
endmodule

bind ce_tracker ce_tracker_chk #(
    .IVL_W (IVL_W),
    .EVT_W (EVT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .conn_start       (conn_start),
    .trk_active       (trk_active),
    .conn_interval_us (conn_interval_us),
    .chan_map         (chan_map),
    .chan_idx         (chan_idx),
    .win_open         (win_open),
    .win_close        (win_close),
    .anchor_upd       (anchor_upd),
    .event_cnt        (event_cnt),
    .sync_lost        (sync_lost),
    .win_widen_us     (win_widen_us)
);

// File: tb/sim_ce_tracker.sv
module sim_ce_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conn_start = 1'b0;
    logic        aa_detect = 1'b0;
    logic [21:0] ivl = '0;
    logic [4:0]  hop = '0;
    logic [36:0] cmap = '0;
    logic [10:0] sca = '0;
    logic [5:0]  chan_idx;
    logic        win_open, win_close, anchor_upd, sync_lost;
    logic [15:0] event_cnt;
    logic [21:0] win_widen_us;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int anchor = 0;
    int exp_unm = 0;
    int exp_evt = 0;
    bit exp_lost = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ce_tracker #(.CLKS_PER_US(1)) u0 (
        .clk(clk), .rst_n(rst_n), .conn_start(conn_start),
        .conn_interval_us(ivl), .hop_incr(hop), .chan_map(cmap),
        .sca_sum_ppm(sca), .aa_detect(aa_detect), .chan_idx(chan_idx),
        .win_open(win_open), .win_close(win_close), .anchor_upd(anchor_upd),
        .event_cnt(event_cnt), .sync_lost(sync_lost), .win_widen_us(win_widen_us)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nxt_unm(input int p);
        return (p + int'(hop)) % 37;
    endfunction

    function automatic int map_ch(input int u);
        int n = 0;
        int k = 0;
        int idx;
        if (cmap[u]) return u;
        for (int i = 0; i < 37; i++) if (cmap[i]) n++;
        if (n == 0) return 0;
        idx = u % n;
        for (int i = 0; i < 37; i++) begin
            if (cmap[i]) begin
                if (k == idx) return i;
                k++;
            end
        end
        return 0;
    endfunction

    task automatic calc_w(input int t, output int w, output bit cl);
        longint raw;
        int half;
        raw  = (longint'(t) * longint'(sca) + 999999) / 1000000 + 16;
        half = int'(ivl) / 2;
        cl   = (raw >= half);
        w    = cl ? half - 1 : int'(raw);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_conn();
        @(negedge clk);
        conn_start = 1'b1;
        @(negedge clk);
        conn_start = 1'b0;
        anchor   = cyc;
        exp_unm  = nxt_unm(0);
        exp_evt  = 0;
        exp_lost = 0;
        chk(chan_idx == 6'(map_ch(exp_unm)), "R10", "first channel", chan_idx, map_ch(exp_unm));
        chk(event_cnt == 0, "R10", "event count at start", event_cnt, 0);
        chk(sync_lost == 1'b0, "R10", "sync_lost at start", sync_lost, 0);
    endtask

    // one connection event; det < 0 means the central's packet is lost
    task automatic run_event(input int tgt, input int det);
        int  w;
        bit  cl;
        bit  seen = 0;
        calc_w(tgt, w, cl);
        if (cl) exp_lost = 1;
        for (int i = 0; i < tgt + 200 && !seen; i++) begin
            @(negedge clk);
            if (win_open) seen = 1;
        end
        chk(seen, "R2", "window opened", seen, 1);
        chk(cyc - anchor == tgt - w + 1, "R2", "open time", cyc - anchor, tgt - w + 1);
        chk(int'(win_widen_us) == w, "R3", "widening", win_widen_us, w);
        chk(sync_lost == exp_lost, "R9", "sync_lost", sync_lost, exp_lost);
        if (det >= 0) begin
            while (cyc - anchor < det) @(negedge clk);
            aa_detect = 1'b1;
            @(negedge clk);
            aa_detect = 1'b0;
            chk(win_close && anchor_upd, "R5", "close+anchor on detect",
                {win_close, anchor_upd}, 3);
            anchor = cyc;
        end else begin
            seen = 0;
            for (int i = 0; i < 4 * w + 10 && !seen; i++) begin
                @(negedge clk);
                if (win_close) seen = 1;
            end
            chk(cyc - anchor == tgt + w + 1, "R4", "close time on miss", cyc - anchor, tgt + w + 1);
            chk(!anchor_upd, "R4", "no anchor on miss", anchor_upd, 0);
        end
        exp_unm = nxt_unm(exp_unm);
        exp_evt++;
        chk(chan_idx == 6'(map_ch(exp_unm)), "R7", "channel after event", chan_idx, map_ch(exp_unm));
        chk(int'(event_cnt) == exp_evt, "R8", "event count", event_cnt, exp_evt);
    endtask

    task automatic t_reset();
        do_reset();
        chk(chan_idx == 0 && event_cnt == 0, "R1", "idle chan/count", {chan_idx, event_cnt}, 0);
        chk(!win_open && !win_close && !anchor_upd && !sync_lost, "R1", "idle strobes",
            {win_open, win_close, anchor_upd, sync_lost}, 0);
        aa_detect = 1'b1;
        @(negedge clk);
        aa_detect = 1'b0;
        repeat (3) @(negedge clk);
        chk(!anchor_upd && !win_close && event_cnt == 0, "R1", "detect while idle",
            {anchor_upd, win_close}, 0);
    endtask

    task automatic t_basic();
        ivl = 22'd1000; hop = 5'd7; cmap = {37{1'b1}}; sca = 11'd500;
        do_reset();
        start_conn();
        run_event(1000, 1000);
        run_event(1000, -1);
        run_event(2000, 2005);
        // stray detection well before the next window (R6)
        while (cyc - anchor < 10) @(negedge clk);
        aa_detect = 1'b1;
        @(negedge clk);
        aa_detect = 1'b0;
        chk(!anchor_upd && !win_close, "R6", "detect outside window", {anchor_upd, win_close}, 0);
        run_event(1000, -1);
        run_event(2000, -1);
        run_event(3000, 3000);
    endtask

    task automatic t_remap();
        ivl = 22'd200; hop = 5'd8; cmap = 37'h10_0010_0222; sca = 11'd50;
        do_reset();
        start_conn();
        for (int k = 1; k <= 8; k++) run_event(200 * k, -1);
        run_event(1800, 1800);
    endtask

    task automatic t_clamp();
        ivl = 22'd60; hop = 5'd12; cmap = {37{1'b1}}; sca = 11'd2000;
        do_reset();
        start_conn();
        for (int k = 1; k <= 113; k++) run_event(60 * k, -1);
        chk(sync_lost, "R9", "lost after long miss run", sync_lost, 1);
        run_event(60 * 114, 60 * 114);
        run_event(60, -1);
        chk(sync_lost, "R9", "lost stays after detect", sync_lost, 1);
        start_conn();
        run_event(60, 60);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_remap();
        t_clamp();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule